// File: doc/BRIEF.md
# Multiprocessor-Filtering UART Receiver

This block is the receive half of an asynchronous serial port. It is meant for multi-drop links where a single line carries traffic for several stations. It samples the serial input on a 16x sample enable that is supplied from outside. Each frame it assembles has a start bit, eight data bits sent least significant bit first, an optional address-marker bit and one stop bit. A finished frame moves into a receive data register. The block then updates three sticky status flags (data present, bad stop bit, data lost) and the stored marker bit. It raises two interrupt requests, one for receive-full and one for receive-error, and each request has its own enable.

In multiprocessor mode, software can arm a wake-up filter. While the filter is armed, every frame whose marker bit is 0 is thrown away without a trace: the data register, the flags and the interrupts do not change. The first frame with the marker bit set to 1 is taken as an ID frame. It is delivered like any normal frame, and it disarms the filter in hardware. Software can then check the address it received and decide whether to keep listening or to arm the filter again.

Top module: `mpr_uart_rx`

## Requirements
- R1: After reset, every control bit, every flag, the data register and both interrupt requests are 0. The control word `ctl_wdata` is written when `ctl_we` is high and read back on `ctl_q`. Its bits are: bit0 receive enable, bit1 multiprocessor mode, bit2 wake-up filter armed, bit3 receive-full interrupt enable, bit4 receive-error interrupt enable.
- R2: A frame is received only if the receiver is enabled and the synchronized line is still low 8 sample ticks after the falling edge. A shorter low pulse, or any traffic while the receiver is disabled, changes nothing.
- R3: Each bit lasts 16 sample ticks and is sampled in its middle. Data arrives LSB first. In multiprocessor mode one marker bit follows the eight data bits, and then one stop bit is sampled.
- R4: An accepted frame that arrives while the full flag (flag bit0) is 0 loads the data register and sets the full flag.
- R5: A stop bit sampled as 0 sets the framing-error flag (flag bit1).
- R6: An accepted frame that arrives while the full flag is 1 sets the overrun flag (flag bit2) and leaves the data register unchanged.
- R7: Writing `flag_wdata` with `flag_we` high clears every flag whose written bit is 0. A written 1 leaves that flag unchanged.
- R8: Clearing the receive enable leaves the full, framing-error and overrun flags unchanged.
- R9: While multiprocessor mode is on and the filter is armed, a frame with marker bit 0 changes neither the data register nor any flag.
- R10: In multiprocessor mode, a frame with marker bit 1 disarms the filter, sets the stored marker bit `st_mpb` and is transferred as a normal frame. Every accepted frame copies its marker bit into `st_mpb`, and outside multiprocessor mode that bit is 0.
- R11: Outside multiprocessor mode, the armed-filter bit has no effect, and every frame is transferred.
- R12: `irq_full` is the full flag gated by enable bit3. `irq_err` is the OR of the framing-error and overrun flags, gated by enable bit4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sample enable at 16 times the bit rate |
| rx_i | input | 1 | Asynchronous serial input, idle high |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word to write |
| flag_we | input | 1 | Flag write strobe, where a 0 clears a flag |
| flag_wdata | input | 3 | Flag mask: bit0 full, bit1 framing error, bit2 overrun |
| ctl_q | output | 5 | Control word readback, including the live filter bit |
| rx_data | output | 8 | Receive data register |
| st_full | output | 1 | Receive data full flag |
| st_ferr | output | 1 | Framing error flag |
| st_ovr | output | 1 | Overrun flag |
| st_mpb | output | 1 | Marker bit of the last accepted frame |
| irq_full | output | 1 | Receive-full interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |

## Verification
The hardest state to reach is an ID frame that arrives while the filter is armed and the full flag is still set from earlier traffic. In that case the filter clears itself and an overrun is recorded on the same frame. The bench reaches this state by leaving the flags uncleared, arming the filter through the control word and sending a burst of marker-0 frames before the marker-1 frame. The random phase mixes filter arming, partial flag clears, frames with bad stop bits, and two different sample-enable rates. Short low glitches on the line check that false starts are rejected.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    localparam int MPR_DATA_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_MARK,
        RX_STOP
    } rx_state_e;

    // Control word: bit4 err_ie ... bit0 rx_en
    typedef struct packed {
        logic err_ie;
        logic full_ie;
        logic wake_en;
        logic mp_mode;
        logic rx_en;
    } ctl_t;

    // Flags: bit2 overrun, bit1 framing error, bit0 full
    typedef struct packed {
        logic ovr;
        logic ferr;
        logic full;
    } flags_t;

    typedef struct packed {
        logic                  valid;
        logic [MPR_DATA_W-1:0] data;
        logic                  mpb;
        logic                  stop_bad;
    } frame_t;

    // Software clears a flag by writing 0 into its position.
    function automatic flags_t flag_clear(flags_t cur, flags_t wmask);
        return cur & wmask;
    endfunction

    // A frame is dropped only when the wake filter is active and it carries no ID mark.
    function automatic logic frame_taken(ctl_t c, frame_t f);
        return f.valid & ~(c.mp_mode & c.wake_en & ~f.mpb);
    endfunction

endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[g] <= 1'b1;
                    else     pipe[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[g] <= 1'b1;
                    else     pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/mpr_frame_rx.sv
module mpr_frame_rx
    import mpr_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   rx_s,
    input  logic   rx_en,
    input  logic   mp_mode,
    output frame_t frm
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(MPR_DATA_W);
    localparam logic [CW-1:0] MID_CNT  = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OVS - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(MPR_DATA_W - 1);

    rx_state_e             st;
    logic [CW-1:0]         cnt;
    logic [BW-1:0]         bcnt;
    logic [MPR_DATA_W-1:0] shreg;
    logic                  mark_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RX_IDLE;
            cnt    <= '0;
            bcnt   <= '0;
            shreg  <= '0;
            mark_r <= 1'b0;
            frm    <= '0;
        end else begin
            frm.valid <= 1'b0;
            if (!rx_en) begin
                st  <= RX_IDLE;
                cnt <= '0;
            end else if (tick) begin
                unique case (st)
                    RX_IDLE: begin
                        cnt <= '0;
                        if (!rx_s) st <= RX_START;
                    end
                    RX_START: begin
                        if (cnt == MID_CNT) begin
                            cnt    <= '0;
                            bcnt   <= '0;
                            mark_r <= 1'b0;
                            st     <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == LAST_CNT) begin
                            cnt   <= '0;
                            shreg <= {rx_s, shreg[MPR_DATA_W-1:1]};
                            if (bcnt == LAST_BIT) st <= mp_mode ? RX_MARK : RX_STOP;
                            else                  bcnt <= bcnt + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_MARK: begin
                        if (cnt == LAST_CNT) begin
                            cnt    <= '0;
                            mark_r <= rx_s;
                            st     <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == LAST_CNT) begin
                            cnt          <= '0;
                            frm.valid    <= 1'b1;
                            frm.data     <= shreg;
                            frm.mpb      <= mp_mode & mark_r;
                            frm.stop_bad <= ~rx_s;
                            st           <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mpr_flag_ctl.sv
module mpr_flag_ctl
    import mpr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  frame_t                frm,
    input  logic                  ctl_we,
    input  ctl_t                  ctl_wdata,
    input  logic                  flag_we,
    input  flags_t                flag_wdata,
    output ctl_t                  ctl_r,
    output flags_t                flags_r,
    output logic [MPR_DATA_W-1:0] data_r,
    output logic                  mpb_r
);
    ctl_t                  ctl_n;
    flags_t                flags_n;
    logic [MPR_DATA_W-1:0] data_n;
    logic                  mpb_n;
    logic                  take;
    logic                  id_hit;

    assign take   = frame_taken(ctl_r, frm);
    assign id_hit = frm.valid & ctl_r.mp_mode & frm.mpb;

    always_comb begin
        ctl_n   = ctl_r;
        flags_n = flags_r;
        data_n  = data_r;
        mpb_n   = mpb_r;
        if (ctl_we)  ctl_n   = ctl_wdata;
        if (flag_we) flags_n = flag_clear(flags_r, flag_wdata);
        if (take) begin
            mpb_n = frm.mpb;
            if (frm.stop_bad) flags_n.ferr = 1'b1;
            if (flags_r.full) begin
                flags_n.ovr = 1'b1;
            end else begin
                flags_n.full = 1'b1;
                data_n       = frm.data;
            end
        end
        if (id_hit) ctl_n.wake_en = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_r   <= '0;
            flags_r <= '0;
            data_r  <= '0;
            mpb_r   <= 1'b0;
        end else begin
            ctl_r   <= ctl_n;
            flags_r <= flags_n;
            data_r  <= data_n;
            mpb_r   <= mpb_n;
        end
    end
endmodule

// File: rtl/mpr_uart_rx.sv
module mpr_uart_rx
    import mpr_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick16,
    input  logic                  rx_i,
    input  logic                  ctl_we,
    input  logic [4:0]            ctl_wdata,
    input  logic                  flag_we,
    input  logic [2:0]            flag_wdata,
    output logic [4:0]            ctl_q,
    output logic [MPR_DATA_W-1:0] rx_data,
    output logic                  st_full,
    output logic                  st_ferr,
    output logic                  st_ovr,
    output logic                  st_mpb,
    output logic                  irq_full,
    output logic                  irq_err
);
    logic   rx_s;
    frame_t frm;
    ctl_t   ctl_r;
    flags_t flags_r;
    logic   frm_valid;
    logic   frm_mpb;

    mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (rx_i),
        .q_o (rx_s)
    );

    mpr_frame_rx #(.OVS(OVS)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .rx_s    (rx_s),
        .rx_en   (ctl_r.rx_en),
        .mp_mode (ctl_r.mp_mode),
        .frm     (frm)
    );

    mpr_flag_ctl u_flags (
        .clk        (clk),
        .rst        (rst),
        .frm        (frm),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_t'(ctl_wdata)),
        .flag_we    (flag_we),
        .flag_wdata (flags_t'(flag_wdata)),
        .ctl_r      (ctl_r),
        .flags_r    (flags_r),
        .data_r     (rx_data),
        .mpb_r      (st_mpb)
    );

    assign frm_valid = frm.valid;
    assign frm_mpb   = frm.mpb;
    assign ctl_q     = ctl_r;
    assign st_full   = flags_r.full;
    assign st_ferr   = flags_r.ferr;
    assign st_ovr    = flags_r.ovr;
    assign irq_full  = flags_r.full & ctl_r.full_ie;
    assign irq_err   = (flags_r.ferr | flags_r.ovr) & ctl_r.err_ie;
endmodule

// File: rtl/mpr_uart_rx_chk.sv
module mpr_uart_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       frm_valid,
    input logic       frm_mpb,
    input logic       flag_we,
    input logic [4:0] ctl_q,
    input logic [7:0] rx_data,
    input logic       st_full,
    input logic       st_ferr,
    input logic       st_ovr,
    input logic       st_mpb,
    input logic       irq_full,
    input logic       irq_err
);
    // R9
    filter_drop_chk: assert property (@(posedge clk) disable iff (rst)
        frm_valid && ctl_q[1] && ctl_q[2] && !frm_mpb && !flag_we
        |=> $stable({st_full, st_ferr, st_ovr}) && $stable(rx_data));

    // R10
    wake_clear_chk: assert property (@(posedge clk) disable iff (rst)
        frm_valid && ctl_q[1] && frm_mpb |=> !ctl_q[2] && st_mpb);

    // R6
    overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
        frm_valid && st_full && !(ctl_q[1] && ctl_q[2] && !frm_mpb)
        |=> st_ovr && $stable(rx_data));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frm_valid && !flag_we |=> $stable({st_full, st_ferr, st_ovr}));

    // R4
    full_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_full) |-> $past(frm_valid));

    // R12
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_full |-> st_full) and (irq_err |-> (st_ferr || st_ovr)));
endmodule

bind mpr_uart_rx mpr_uart_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frm_valid (frm_valid),
    .frm_mpb   (frm_mpb),
    .flag_we   (flag_we),
    .ctl_q     (ctl_q),
    .rx_data   (rx_data),
    .st_full   (st_full),
    .st_ferr   (st_ferr),
    .st_ovr    (st_ovr),
    .st_mpb    (st_mpb),
    .irq_full  (irq_full),
    .irq_err   (irq_err)
);

// File: tb/mpr_uart_rx_tb_top.sv
module mpr_uart_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rx_i = 1'b1;
    logic       ctl_we = 1'b0;
    logic [4:0] ctl_wdata = '0;
    logic       flag_we = 1'b0;
    logic [2:0] flag_wdata = '0;
    logic [4:0] ctl_q;
    logic [7:0] rx_data;
    logic       st_full, st_ferr, st_ovr, st_mpb, irq_full, irq_err;

    int n_checks = 0;
    int n_errors = 0;
    int tick_div = 1;

    logic [4:0] e_ctl  = '0;
    logic [7:0] e_data = '0;
    logic       e_full = 0, e_ferr = 0, e_ovr = 0, e_mpb = 0;

    always #5 clk = ~clk;

    mpr_uart_rx dut_i (
        .clk(clk), .rst(rst), .tick16(tick16), .rx_i(rx_i),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .flag_we(flag_we), .flag_wdata(flag_wdata),
        .ctl_q(ctl_q), .rx_data(rx_data),
        .st_full(st_full), .st_ferr(st_ferr), .st_ovr(st_ovr), .st_mpb(st_mpb),
        .irq_full(irq_full), .irq_err(irq_err)
    );

    // sample-enable generator
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc++;
            if (tc >= tick_div) begin tick16 = 1'b1; tc = 0; end
            else tick16 = 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        @(negedge clk);
        chk(req, "ctl_q", int'(ctl_q), int'(e_ctl));
        chk(req, "rx_data", int'(rx_data), int'(e_data));
        chk(req, "full", int'(st_full), int'(e_full));
        chk(req, "ferr", int'(st_ferr), int'(e_ferr));
        chk(req, "ovr", int'(st_ovr), int'(e_ovr));
        chk(req, "mpb", int'(st_mpb), int'(e_mpb));
        // R12 interrupt gating
        chk(req, "irq_full", int'(irq_full), int'(e_full & e_ctl[3]));
        chk(req, "irq_err", int'(irq_err), int'((e_ferr | e_ovr) & e_ctl[4]));
    endtask

    task automatic hold_line(input logic b, input int nticks);
        @(negedge clk);
        rx_i = b;
        for (int n = 0; n < nticks; ) begin
            @(posedge clk);
            if (tick16) n++;
        end
    endtask

    task automatic write_ctl(input logic [4:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
        e_ctl = v;
    endtask

    task automatic write_flags(input logic [2:0] m);
        @(negedge clk);
        flag_we = 1'b1; flag_wdata = m;
        @(negedge clk);
        flag_we = 1'b0;
        e_full &= m[0]; e_ferr &= m[1]; e_ovr &= m[2];
    endtask

    // reference model of one frame reaching the register stage
    task automatic model_frame(input logic [7:0] d, input logic mk, input logic bad);
        logic mp;
        mp = e_ctl[1];
        if (!e_ctl[0]) return;
        if (mp && e_ctl[2] && !mk) return;
        if (mp && mk) e_ctl[2] = 1'b0;
        e_mpb = mp & mk;
        if (bad) e_ferr = 1'b1;
        if (e_full) e_ovr = 1'b1;
        else begin e_full = 1'b1; e_data = d; end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic mk, input logic bad);
        hold_line(1'b0, 16);
        for (int i = 0; i < 8; i++) hold_line(d[i], 16);
        if (e_ctl[1]) hold_line(mk, 16);
        if (bad) begin hold_line(1'b0, 10); hold_line(1'b1, 6); end
        else hold_line(1'b1, 16);
        hold_line(1'b1, 4);
        model_frame(d, mk, bad);
    endtask

    initial begin
        #1_500_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check_all("R1 reset");

        // R2 receiver disabled: frame ignored
        send_frame(8'h3C, 1'b0, 1'b0);
        check_all("R2 disabled");

        write_ctl(5'b00001);
        check_all("R1 ctl readback");

        // R2 short low glitch rejected
        hold_line(1'b0, 4);
        hold_line(1'b1, 24);
        check_all("R2 glitch");

        // R3 LSB-first assembly, R4 load
        send_frame(8'h01, 1'b0, 1'b0);
        check_all("R3 R4 first frame");
        write_ctl(5'b01001);
        check_all("R12 full irq");

        // R6 overrun keeps data
        send_frame(8'hA5, 1'b0, 1'b0);
        check_all("R6 overrun");
        write_ctl(5'b11001);
        check_all("R12 err irq");

        // R7 writing ones changes nothing, zeros clear
        write_flags(3'b111);
        check_all("R7 ones");
        write_flags(3'b000);
        check_all("R7 clear");

        // R5 bad stop bit
        send_frame(8'h80, 1'b0, 1'b1);
        check_all("R5 framing");

        // R8 disable keeps flags
        write_ctl(5'b11000);
        check_all("R8 disable");
        write_ctl(5'b11001);
        write_flags(3'b000);

        // R9 filter armed in mp mode
        write_ctl(5'b11111);
        send_frame(8'h55, 1'b0, 1'b0);
        send_frame(8'h66, 1'b0, 1'b1);
        check_all("R9 filtered");

        // R10 ID frame
        send_frame(8'h92, 1'b1, 1'b0);
        check_all("R10 id frame");
        write_flags(3'b000);
        send_frame(8'h17, 1'b0, 1'b0);
        check_all("R10 normal after id");

        // R10 ID frame while full already set
        write_ctl(5'b11111);
        send_frame(8'h44, 1'b0, 1'b0);
        send_frame(8'hC3, 1'b1, 1'b0);
        check_all("R10 R6 id overrun");
        write_flags(3'b000);

        // R11 filter bit ignored outside mp mode
        write_ctl(5'b11101);
        send_frame(8'h5A, 1'b0, 1'b0);
        check_all("R11 no mp");

        // R3 slower sample enable
        tick_div = 2;
        write_flags(3'b000);
        write_ctl(5'b11011);
        send_frame(8'hE7, 1'b1, 1'b0);
        check_all("R3 mark bit slow ticks");

        // random phase
        for (int it = 0; it < 40; it++) begin
            int op;
            op = int'($urandom % 8);
            tick_div = 1 + int'($urandom % 2);
            if (op < 5) begin
                send_frame(8'($urandom), 1'($urandom), ($urandom % 8) == 0);
                check_all("R4 random frame");
            end else if (op == 5) begin
                write_flags(3'($urandom));
                check_all("R7 random clear");
            end else if (op == 6) begin
                logic [4:0] v;
                v = 5'($urandom);
                if (($urandom % 10) != 0) v[0] = 1'b1;
                write_ctl(v);
                check_all("R1 random ctl");
            end else begin
                write_ctl({e_ctl[4:3], 3'b111});
                check_all("R9 random arm");
            end
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule